// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts, for a load or store entering an out-of-order core, which older in-flight store it should wait for. It keeps two tables. The set table is indexed by a hash of the instruction address and holds a store-set number. The producer table is indexed by that set number and holds the sequence number and thread tag of the most recently fetched store of the set. Every entry of both tables has its own valid bit.

The core presents an instruction address on the lookup port and receives the sequence number of the store to wait for, or zero when none is predicted. When a memory-ordering violation is detected, the store and load addresses are trained into a shared set. Stores are recorded when they are inserted. A producer entry is dropped when its store issues, or when a squash removes it. Every recorded memory operation advances a counter, and when that counter reaches the configured period, both tables are wiped so that stale sets do not pile up. An explicit clear input wipes them at any time.

Top module: `store_set_predictor`

## Requirements
- R1: After reset every valid bit of both tables is clear, the insert counter is zero, and every lookup returns 0.
- R2: The set-table index is `(pc >> ADDR_SHIFT) mod SET_DEPTH`. With the defaults (shift 2, 64 entries), addresses that differ only in bits 1:0 use the same entry.
- R3: A lookup returns the stored producer sequence number only when the set entry for its address is valid and the producer entry for that set is valid. In every other case it returns 0. The lookup output is combinational on the table state.
- R4: A violation where neither address has a valid set entry writes both entries valid with the set number `(store_pc XOR (store_pc >> 10)) mod PROD_DEPTH`.
- R5: A violation where exactly one of the two addresses has a valid set entry gives the other address that set number. A violation where both are valid gives both the smaller of the two set numbers.
- R6: Inserting a store (`ins_is_store`=1) whose address has a valid set entry writes its sequence number and thread tag into that set's producer entry and marks it valid. A store without a valid set entry, or any load insert (`ins_is_store`=0), leaves both tables unchanged.
- R7: Issuing a store whose set is valid and whose producer entry holds exactly its sequence number invalidates that producer entry. A store with a different sequence number, or any issued load, has no effect.
- R8: A squash with thread tag T and sequence number N invalidates every valid producer entry whose tag equals T and whose sequence number is greater than N (unsigned). No other entry changes.
- R9: Each insert, load or store, counts one operation. The insert that brings the count to CLEAR_PERIOD does not take effect. Instead it wipes every valid bit of both tables and restarts the count at zero.
- R10: An asserted `clear_all` wipes every valid bit of both tables and zeroes the count. It takes priority over any violation, insert, issue or squash in the same cycle.
- R11: Within one cycle, the insert and issue ports read the set table as it was before that clock edge. A violation in the same cycle takes effect after that edge. The producer-table updates are applied in the order insert, then issue, then squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address to look up |
| lk_seq | output | SEQ_W | Predicted producer sequence number, 0 when none |
| ins_valid | input | 1 | Insert a memory operation |
| ins_is_store | input | 1 | 1 for a store insert, 0 for a load |
| ins_pc | input | PC_W | Address of the inserted operation |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation |
| ins_tid | input | TID_W | Thread tag of the inserted operation |
| viol_valid | input | 1 | Train on an ordering violation |
| viol_store_pc | input | PC_W | Address of the older store |
| viol_load_pc | input | PC_W | Address of the younger load |
| iss_valid | input | 1 | An operation issues |
| iss_is_store | input | 1 | 1 when the issued operation is a store |
| iss_pc | input | PC_W | Address of the issued operation |
| iss_seq | input | SEQ_W | Sequence number of the issued operation |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread tag to squash |
| sq_seq | input | SEQ_W | Entries younger than this number are removed |
| clear_all | input | 1 | Wipe both tables and the counter |

## Verification
The assertions assume that `rst_n` is low for at least one clock edge before any other input is used. They also assume that every input is stable and known around the rising edge. They do not depend on any ordering between sequence numbers, so producer entries may hold equal or decreasing values. The stimulus changes inputs only on the falling edge and draws addresses from a small pool, so sets collide and merge often. Sequence numbers for issues are frequently copied from the model's producer entries so that retirement is exercised, and clears and wipes arrive while other ports are busy.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Outcome of merging two set-table entries on a violation.
  typedef enum logic [1:0] {
    MERGE_FRESH      = 2'd0,
    MERGE_TAKE_STORE = 2'd1,
    MERGE_TAKE_LOAD  = 2'd2,
    MERGE_SMALLER    = 2'd3
  } merge_e;

  // Set-table index: drop the low address bits, then fold to the depth.
  function automatic int unsigned ssp_index(input logic [63:0] pc,
                                            input int unsigned shift,
                                            input int unsigned depth);
    return 32'((pc >> shift) % 64'(depth));
  endfunction

  // Fresh set number derived from the store address.
  function automatic int unsigned ssp_fresh_id(input logic [63:0] pc,
                                               input int unsigned depth);
    return 32'((pc ^ (pc >> 10)) % 64'(depth));
  endfunction

endpackage

// File: rtl/ssp_set_table.sv
module ssp_set_table
  import ssp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SET_DEPTH  = 64,
  parameter int PROD_DEPTH = 16,
  parameter int ADDR_SHIFT = 2,
  parameter int NRD        = 3,
  localparam int IDX_W     = $clog2(SET_DEPTH),
  localparam int ID_W      = $clog2(PROD_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe,
  input  logic [PC_W-1:0] rd_pc  [NRD],
  output logic            rd_hit [NRD],
  output logic [ID_W-1:0] rd_id  [NRD],
  input  logic            train_valid,
  input  logic [PC_W-1:0] train_store_pc,
  input  logic [PC_W-1:0] train_load_pc
);

  logic [SET_DEPTH-1:0] vld;
  logic [ID_W-1:0]      ids [SET_DEPTH];

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return IDX_W'(ssp_index(64'(pc), ADDR_SHIFT, SET_DEPTH));
  endfunction

  // Read ports: lookup, insert and issue all see the pre-edge state.
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [IDX_W-1:0] ridx;
    assign ridx      = idx_of(rd_pc[r]);
    assign rd_hit[r] = vld[ridx];
    assign rd_id[r]  = ids[ridx];
  end

  // Violation training: both addresses end up with one common set number.
  logic [IDX_W-1:0] sidx, lidx;
  logic             s_ok, l_ok;
  logic [ID_W-1:0]  s_id, l_id, fresh_id, join_id;
  merge_e           merge_kind;

  always_comb begin
    sidx     = idx_of(train_store_pc);
    lidx     = idx_of(train_load_pc);
    s_ok     = vld[sidx];
    l_ok     = vld[lidx];
    s_id     = ids[sidx];
    l_id     = ids[lidx];
    fresh_id = ID_W'(ssp_fresh_id(64'(train_store_pc), PROD_DEPTH));
    case ({s_ok, l_ok})
      2'b10:   merge_kind = MERGE_TAKE_STORE;
      2'b01:   merge_kind = MERGE_TAKE_LOAD;
      2'b11:   merge_kind = MERGE_SMALLER;
      default: merge_kind = MERGE_FRESH;
    endcase
    case (merge_kind)
      MERGE_TAKE_STORE: join_id = s_id;
      MERGE_TAKE_LOAD:  join_id = l_id;
      MERGE_SMALLER:    join_id = (s_id < l_id) ? s_id : l_id;
      default:          join_id = fresh_id;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (wipe) begin
      vld <= '0;
    end else if (train_valid) begin
      vld[sidx] <= 1'b1;
      vld[lidx] <= 1'b1;
      ids[sidx] <= join_id;
      ids[lidx] <= join_id;
    end
  end

  // R4 / R5: after training, both entries are valid and share a set number.
  assert_train_joins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (train_valid && !wipe) |=>
      (vld[$past(sidx)] && vld[$past(lidx)] && ids[$past(sidx)] == ids[$past(lidx)]));

  // R5: a merge of two valid sets never raises the store's set number.
  assert_merge_not_larger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (train_valid && !wipe && s_ok && l_ok) |=> (ids[$past(sidx)] <= $past(s_id)));

  // R10: a wipe leaves the set table empty.
  assert_set_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (vld == '0));

endmodule

// File: rtl/ssp_producer_table.sv
module ssp_producer_table #(
  parameter int PROD_DEPTH = 16,
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 1,
  localparam int ID_W      = $clog2(PROD_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic [ID_W-1:0]  rd_id,
  output logic             rd_valid,
  output logic [SEQ_W-1:0] rd_seq,
  input  logic             ins_fire,
  input  logic [ID_W-1:0]  ins_id,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [TID_W-1:0] ins_tid,
  input  logic             iss_fire,
  input  logic [ID_W-1:0]  iss_id,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq
);

  logic [PROD_DEPTH-1:0] vld;
  logic [SEQ_W-1:0]      seq_q [PROD_DEPTH];
  logic [TID_W-1:0]      tid_q [PROD_DEPTH];

  // Staged next state: insert, then issue, then squash.
  logic [PROD_DEPTH-1:0] v_ins, v_iss, v_fin, sq_kill;
  logic [SEQ_W-1:0]      s_ins [PROD_DEPTH];
  logic [TID_W-1:0]      t_ins [PROD_DEPTH];
  logic                  iss_hit;

  always_comb begin
    v_ins = vld;
    s_ins = seq_q;
    t_ins = tid_q;
    if (ins_fire) begin
      v_ins[ins_id] = 1'b1;
      s_ins[ins_id] = ins_seq;
      t_ins[ins_id] = ins_tid;
    end
    iss_hit = iss_fire && v_ins[iss_id] && (s_ins[iss_id] == iss_seq);
    v_iss = v_ins;
    if (iss_hit) v_iss[iss_id] = 1'b0;
    for (int e = 0; e < PROD_DEPTH; e++) begin
      sq_kill[e] = sq_valid && v_iss[e] && (t_ins[e] == sq_tid) && (s_ins[e] > sq_seq);
    end
    v_fin = v_iss & ~sq_kill;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (wipe) begin
      vld <= '0;
    end else begin
      vld   <= v_fin;
      seq_q <= s_ins;
      tid_q <= t_ins;
    end
  end

  assign rd_valid = vld[rd_id];
  assign rd_seq   = seq_q[rd_id];

  // R10: a wipe leaves the producer table empty.
  assert_prod_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (vld == '0));

  // R7: a matching store issue retires its producer entry.
  assert_issue_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_hit && !wipe) |=> !vld[$past(iss_id)]);

  // R6: an insert that is not undone later in the same cycle lands.
  assert_insert_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !wipe && !(iss_fire && iss_id == ins_id && iss_seq == ins_seq)
     && !(sq_valid && sq_tid == ins_tid && ins_seq > sq_seq))
    |=> (vld[$past(ins_id)] && seq_q[$past(ins_id)] == $past(ins_seq)));

  // R8: after a squash no younger entry of that thread survives.
  for (genvar e = 0; e < PROD_DEPTH; e++) begin : g_sq_chk
    assert_squash_prunes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid && !wipe) |=>
        !(vld[e] && tid_q[e] == $past(sq_tid) && seq_q[e] > $past(sq_seq)));
  end

endmodule

// File: rtl/ssp_clear_timer.sv
module ssp_clear_timer #(
  parameter int CLEAR_PERIOD = 32,
  localparam int CNT_W       = $clog2(CLEAR_PERIOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear_req,
  output logic wipe
);

  logic [CNT_W-1:0] cnt;
  logic             period_end;

  assign period_end = tick && (cnt == CNT_W'(CLEAR_PERIOD - 1));
  assign wipe       = clear_req || period_end;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wipe) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R9: the count never reaches the period itself.
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(CLEAR_PERIOD));

  // R9 / R10: every wipe restarts the count.
  assert_wipe_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (cnt == '0));

  // R9: a counted insert with no wipe advances the count by one.
  assert_tick_advances_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wipe) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W         = 32,
  parameter int SEQ_W        = 16,
  parameter int TID_W        = 1,
  parameter int SET_DEPTH    = 64,
  parameter int PROD_DEPTH   = 16,
  parameter int ADDR_SHIFT   = 2,
  parameter int CLEAR_PERIOD = 32,
  localparam int ID_W        = $clog2(PROD_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic [SEQ_W-1:0] lk_seq,
  input  logic             ins_valid,
  input  logic             ins_is_store,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [TID_W-1:0] ins_tid,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_store_pc,
  input  logic [PC_W-1:0]  viol_load_pc,
  input  logic             iss_valid,
  input  logic             iss_is_store,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             clear_all
);

  localparam int RD_LK  = 0;
  localparam int RD_INS = 1;
  localparam int RD_ISS = 2;

  logic [PC_W-1:0] rd_pc  [3];
  logic            rd_hit [3];
  logic [ID_W-1:0] rd_id  [3];

  logic             wipe;
  logic             ins_fire, iss_fire;
  logic             prod_valid;
  logic [SEQ_W-1:0] prod_seq;

  always_comb begin
    rd_pc[RD_LK]  = lk_pc;
    rd_pc[RD_INS] = ins_pc;
    rd_pc[RD_ISS] = iss_pc;
  end

  // Named internal events for the assertions.
  assign ins_fire = ins_valid && ins_is_store && rd_hit[RD_INS];
  assign iss_fire = iss_valid && iss_is_store && rd_hit[RD_ISS];

  ssp_clear_timer #(.CLEAR_PERIOD(CLEAR_PERIOD)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (ins_valid),
    .clear_req (clear_all),
    .wipe      (wipe)
  );

  ssp_set_table #(
    .PC_W(PC_W), .SET_DEPTH(SET_DEPTH), .PROD_DEPTH(PROD_DEPTH),
    .ADDR_SHIFT(ADDR_SHIFT), .NRD(3)
  ) u_sets (
    .clk            (clk),
    .rst_n          (rst_n),
    .wipe           (wipe),
    .rd_pc          (rd_pc),
    .rd_hit         (rd_hit),
    .rd_id          (rd_id),
    .train_valid    (viol_valid),
    .train_store_pc (viol_store_pc),
    .train_load_pc  (viol_load_pc)
  );

  ssp_producer_table #(
    .PROD_DEPTH(PROD_DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W)
  ) u_prod (
    .clk      (clk),
    .rst_n    (rst_n),
    .wipe     (wipe),
    .rd_id    (rd_id[RD_LK]),
    .rd_valid (prod_valid),
    .rd_seq   (prod_seq),
    .ins_fire (ins_fire),
    .ins_id   (rd_id[RD_INS]),
    .ins_seq  (ins_seq),
    .ins_tid  (ins_tid),
    .iss_fire (iss_fire),
    .iss_id   (rd_id[RD_ISS]),
    .iss_seq  (iss_seq),
    .sq_valid (sq_valid),
    .sq_tid   (sq_tid),
    .sq_seq   (sq_seq)
  );

  assign lk_seq = (rd_hit[RD_LK] && prod_valid) ? prod_seq : '0;

  // R1 / R10: the cycle after a reset or a clear, no dependence is reported.
  assert_quiet_after_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_all) |-> (lk_seq == '0));

endmodule

// File: tb/store_set_predictor_test.sv
module store_set_predictor_test;

  localparam int PW = 32, SW = 16, NSET = 64, NPROD = 16, SHIFT = 2, PERIOD = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [PW-1:0] lk_pc, ins_pc, viol_store_pc, viol_load_pc, iss_pc;
  logic [SW-1:0] lk_seq, ins_seq, iss_seq, sq_seq;
  logic ins_valid, ins_is_store, viol_valid, iss_valid, iss_is_store, sq_valid, clear_all;
  logic [0:0] ins_tid, sq_tid;

  store_set_predictor #(
    .PC_W(PW), .SEQ_W(SW), .TID_W(1), .SET_DEPTH(NSET), .PROD_DEPTH(NPROD),
    .ADDR_SHIFT(SHIFT), .CLEAR_PERIOD(PERIOD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_seq(lk_seq),
    .ins_valid(ins_valid), .ins_is_store(ins_is_store), .ins_pc(ins_pc),
    .ins_seq(ins_seq), .ins_tid(ins_tid), .viol_valid(viol_valid),
    .viol_store_pc(viol_store_pc), .viol_load_pc(viol_load_pc),
    .iss_valid(iss_valid), .iss_is_store(iss_is_store), .iss_pc(iss_pc),
    .iss_seq(iss_seq), .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .clear_all(clear_all)
  );

  // Staged stimulus, copied to the ports at the falling edge.
  logic [PW-1:0] b_lk, b_ipc, b_vs, b_vl, b_upc;
  logic [SW-1:0] b_iseq, b_useq, b_qseq;
  logic b_ins, b_ist, b_viol, b_iss, b_ust, b_sq, b_clr;
  logic [0:0] b_itid, b_qtid;

  // Reference model state.
  bit            m_sv  [NSET];
  int unsigned   m_sid [NSET];
  bit            m_pv  [NPROD];
  logic [SW-1:0] m_ps  [NPROD];
  logic [0:0]    m_pt  [NPROD];
  int            m_cnt;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [PW-1:0] pool [8];

  function automatic int unsigned m_idx(input logic [PW-1:0] pc);
    return (pc / 4) % NSET;
  endfunction

  function automatic int unsigned m_hash(input logic [PW-1:0] pc);
    logic [PW-1:0] x;
    x = pc ^ (pc >> 10);
    return x & (NPROD - 1);
  endfunction

  function automatic logic [SW-1:0] m_dep(input logic [PW-1:0] pc);
    int unsigned i;
    i = m_idx(pc);
    if (m_sv[i] && m_pv[m_sid[i]]) return m_ps[m_sid[i]];
    return '0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NSET; i++) begin m_sv[i] = 0; m_sid[i] = 0; end
    for (int i = 0; i < NPROD; i++) begin m_pv[i] = 0; m_ps[i] = '0; m_pt[i] = '0; end
    m_cnt = 0;
  endtask

  // One clock of the reference behaviour, using the staged inputs.
  task automatic m_update();
    int unsigned si, li, ii, ui, nid;
    bit wipe;
    wipe = b_clr || (b_ins && m_cnt == PERIOD - 1);
    if (wipe) begin
      for (int i = 0; i < NSET; i++) m_sv[i] = 0;
      for (int i = 0; i < NPROD; i++) m_pv[i] = 0;
      m_cnt = 0;
      return;
    end
    if (b_ins) m_cnt++;
    ii = m_idx(b_ipc);
    ui = m_idx(b_upc);
    si = m_idx(b_vs);
    li = m_idx(b_vl);
    if (b_ins && b_ist && m_sv[ii]) begin
      m_pv[m_sid[ii]] = 1; m_ps[m_sid[ii]] = b_iseq; m_pt[m_sid[ii]] = b_itid;
    end
    if (b_iss && b_ust && m_sv[ui] && m_pv[m_sid[ui]] && m_ps[m_sid[ui]] == b_useq)
      m_pv[m_sid[ui]] = 0;
    if (b_sq)
      for (int i = 0; i < NPROD; i++)
        if (m_pv[i] && m_pt[i] == b_qtid && m_ps[i] > b_qseq) m_pv[i] = 0;
    if (b_viol) begin
      if (!m_sv[si] && !m_sv[li]) nid = m_hash(b_vs);
      else if (m_sv[si] && !m_sv[li]) nid = m_sid[si];
      else if (!m_sv[si] && m_sv[li]) nid = m_sid[li];
      else nid = (m_sid[si] < m_sid[li]) ? m_sid[si] : m_sid[li];
      m_sv[si] = 1; m_sv[li] = 1; m_sid[si] = nid; m_sid[li] = nid;
    end
  endtask

  task automatic quiet();
    b_ins = 0; b_ist = 0; b_viol = 0; b_iss = 0; b_ust = 0; b_sq = 0; b_clr = 0;
  endtask

  task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lookup pc=%h got %h expected %h", tag, lk_pc, act, exp);
    end
  endtask

  // Drive at the falling edge, compare the lookup, then advance the model.
  task automatic step(input string tag);
    @(negedge clk);
    lk_pc = b_lk; ins_valid = b_ins; ins_is_store = b_ist; ins_pc = b_ipc;
    ins_seq = b_iseq; ins_tid = b_itid; viol_valid = b_viol; viol_store_pc = b_vs;
    viol_load_pc = b_vl; iss_valid = b_iss; iss_is_store = b_ust; iss_pc = b_upc;
    iss_seq = b_useq; sq_valid = b_sq; sq_tid = b_qtid; sq_seq = b_qseq;
    clear_all = b_clr;
    #2;
    if (rst_n) check(tag, lk_seq, m_dep(b_lk));
    @(posedge clk);
    if (!rst_n) m_reset(); else m_update();
    quiet();
  endtask

  task automatic look(input logic [PW-1:0] pc, input string tag);
    b_lk = pc; step(tag);
  endtask

  task automatic viol(input logic [PW-1:0] s, input logic [PW-1:0] l, input string tag);
    b_viol = 1; b_vs = s; b_vl = l; step(tag);
  endtask

  task automatic ins(input bit st, input logic [PW-1:0] pc, input logic [SW-1:0] sq,
                     input logic [0:0] t, input string tag);
    b_ins = 1; b_ist = st; b_ipc = pc; b_iseq = sq; b_itid = t; step(tag);
  endtask

  task automatic iss(input bit st, input logic [PW-1:0] pc, input logic [SW-1:0] sq,
                     input string tag);
    b_iss = 1; b_ust = st; b_upc = pc; b_useq = sq; step(tag);
  endtask

  task automatic squash(input logic [0:0] t, input logic [SW-1:0] sq, input string tag);
    b_sq = 1; b_qtid = t; b_qseq = sq; step(tag);
  endtask

  // Random mixed traffic: percentages per operation.
  task automatic mix(input string tag, input int n, input int pv, input int pi,
                     input int pu, input int pq, input int pc);
    for (int k = 0; k < n; k++) begin
      b_lk = pool[$urandom % 8] + ($urandom % 4);
      if ($urandom % 100 < pv) begin
        b_viol = 1; b_vs = pool[$urandom % 8]; b_vl = pool[$urandom % 8];
      end
      if ($urandom % 100 < pi) begin
        b_ins = 1; b_ist = ($urandom % 4) != 0; b_ipc = pool[$urandom % 8];
        b_iseq = SW'($urandom); b_itid = 1'($urandom);
      end
      if ($urandom % 100 < pu) begin
        b_iss = 1; b_ust = ($urandom % 4) != 0; b_upc = pool[$urandom % 8];
        b_useq = SW'($urandom);
        if (($urandom % 2) == 0 && m_sv[m_idx(b_upc)]) b_useq = m_ps[m_sid[m_idx(b_upc)]];
      end
      if ($urandom % 100 < pq) begin
        b_sq = 1; b_qtid = 1'($urandom); b_qseq = SW'($urandom);
      end
      if ($urandom % 1000 < pc) b_clr = 1;
      step(tag);
    end
  endtask

  localparam logic [PW-1:0] PA = 32'h0000_5a10, PB = 32'h0000_0c48,
                            PC = 32'h0000_3370, PD = 32'h0000_14a4,
                            PE = 32'h0000_2b08;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    b_lk = '0; b_ipc = '0; b_vs = '0; b_vl = '0; b_upc = '0;
    b_iseq = '0; b_useq = '0; b_qseq = '0; b_itid = '0; b_qtid = '0;
    quiet();
    for (int k = 0; k < 8; k++) pool[k] = ($urandom & 32'h0000_3ffc);
    rst_n = 0;
    repeat (3) step("R1 reset");
    rst_n = 1;
    // R1: nothing predicted out of reset
    look(PA, "R1 idle"); look(PB, "R1 idle"); look(pool[0], "R1 idle");
    // R4: fresh set, then a store insert makes the load wait on it
    viol(PA, PB, "R4 fresh set");
    ins(1, PA, 16'h1111, 0, "R4 store join");
    look(PB, "R4 load sees store"); look(PA, "R3 store sees itself");
    // R6: store without a set, and a load insert, change nothing
    ins(1, PC, 16'h0777, 0, "R6 store no set");
    look(PC, "R6 no set");
    ins(0, PB, 16'h0999, 0, "R6 load insert");
    look(PB, "R6 load insert no effect");
    // R5: one-sided copy, then a two-sided merge to the smaller number
    viol(PC, PB, "R5 copy id");
    ins(1, PC, 16'h2222, 0, "R5 shared store");
    look(PB, "R5 copied set"); look(PA, "R5 copied set");
    viol(PD, PE, "R4 second set");
    ins(1, PD, 16'h0444, 1, "R5 second store");
    viol(PD, PB, "R5 both valid");
    look(PE, "R5 merged"); look(PB, "R5 merged"); look(PD, "R5 merged");
    // R7: issue retirement
    ins(1, PA, 16'h2222, 0, "R7 refill");
    iss(1, PA, 16'h2221, "R7 mismatch");
    look(PB, "R7 mismatch kept");
    iss(0, PA, 16'h2222, "R7 load issue");
    look(PB, "R7 load issue kept");
    iss(1, PA, 16'h2222, "R7 match");
    look(PB, "R7 retired");
    // R8: squash filtering on tag and age
    ins(1, PA, 16'h3000, 1, "R8 fill");
    squash(0, 16'h0000, "R8 other thread");
    look(PB, "R8 other thread kept");
    squash(1, 16'h3000, "R8 equal kept");
    look(PB, "R8 equal kept");
    squash(1, 16'h2fff, "R8 younger removed");
    look(PB, "R8 younger removed");
    // R2: low address bits ignored by the index
    ins(1, PA, 16'h4321, 0, "R2 fill");
    look(PB + 1, "R2 offset"); look(PB + 2, "R2 offset"); look(PB + 3, "R2 offset");
    // R11: insert and violation together; issue and squash together
    b_viol = 1; b_vs = PE; b_vl = PC; b_ins = 1; b_ist = 1; b_ipc = PC;
    b_iseq = 16'h5555; b_itid = 0; b_lk = PC; step("R11 same cycle");
    look(PE, "R11 after"); look(PC, "R11 after");
    b_ins = 1; b_ist = 1; b_ipc = PA; b_iseq = 16'h6000; b_itid = 0;
    b_iss = 1; b_ust = 1; b_upc = PA; b_useq = 16'h6000; b_lk = PB;
    step("R11 insert then issue");
    look(PB, "R11 insert then issue");
    // R9: periodic wipe after a run of load inserts
    for (int k = 0; k < PERIOD + 2; k++) ins(0, PB, 16'h0, 0, "R9 period");
    look(PB, "R9 wiped"); look(PE, "R9 wiped");
    // R10: clear beats same-cycle activity
    viol(PA, PB, "R10 setup");
    ins(1, PA, 16'h7777, 0, "R10 setup");
    b_clr = 1; b_viol = 1; b_vs = PC; b_vl = PD; b_ins = 1; b_ist = 1; b_ipc = PA;
    b_iseq = 16'h7778; b_lk = PB; step("R10 clear priority");
    look(PB, "R10 cleared"); look(PC, "R10 cleared");
    // Mixed traffic
    mix("R11 mixed", 3000, 20, 40, 30, 10, 5);
    mix("R9 heavy inserts", 800, 10, 90, 20, 5, 0);
    mix("R8 heavy squash", 600, 25, 50, 10, 40, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule